// File: doc/BRIEF.md
# Indexed-Mask Interrupt Controller

This unit gathers up to 64 level-sensitive interrupt lines and presents one request to the processor. The request is the highest interrupt level among the lines that are active and not masked, together with a vector index for that line. Each line has a mask bit and a small level register. A line with level zero never produces a request.

Software changes mask bits without any read-modify-write. It writes a source index to one of two write-only ports. One port masks that single source and the other unmasks it. Setting the "all sources" bit in the written byte applies the command to every source at once. The mask bytes and the level registers can be read back over the same byte-wide bus.

The address map is as follows:
- 0x00: write-only mask-set command.
- 0x01: write-only mask-clear command.
- 0x08 + k: mask byte k, read-only. Bit j of byte k is the mask of source 8k+j.
- 0x40 + n: level register of source n, read/write.

Top module: `imask_intc`

## Requirements
- R1: After reset all mask bits are 1, every level register reads 0, and `irq_lvl_o` and `irq_vec_o` are 0.
- R2: A write to address 0x00 with data bit 6 clear sets the mask bit of source `data[5:0]` and changes no other mask bit.
- R3: A write to address 0x01 with data bit 6 clear clears the mask bit of source `data[5:0]` and changes no other mask bit.
- R4: A write to address 0x00 with data bit 6 set (for example 0xFF) masks all sources. The same write to address 0x01 unmasks all sources. The other data bits are ignored.
- R5: A write to address 0x40+n stores `data[2:0]` as the level of source n. A read of 0x40+n returns that level with bits 7:3 at zero.
- R6: A source whose level is 0 never wins, even when it is active and unmasked.
- R7: `irq_lvl_o` is the highest level among sources that are active and unmasked, or 0 when there is no such source.
- R8: When several eligible sources share the highest level, the source with the lowest number wins.
- R9: `irq_vec_o` is 64 plus the winning source number, or 0 when `irq_lvl_o` is 0.
- R10: The outputs are registered. They reflect the inputs and the mask and level state as sampled at the previous rising clock edge.
- R11: A read of 0x08+k returns mask bits 8k+7 down to 8k. A read of any unmapped address returns 0. A write to an unmapped address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| irq_i | input | 64 | Level interrupt lines, one per source |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address (combinational read) |
| rd_data_o | output | 8 | Read data |
| irq_lvl_o | output | 3 | Level of the winning request, 0 when there is none |
| irq_vec_o | output | 8 | Vector index of the winning request |

## Verification
The bench builds the unit with its default parameters: 64 sources, 3-bit levels, and a vector base of 64. With these values every source index reachable from the 6-bit command field is a real source, and the vector output covers 64 to 127. Directed phases cover ties, level-zero sources, the all-sources command on both ports, and unmapped writes. A long phase of random writes and random line patterns then runs against a behavioural model. That model is compared on every clock, so it exercises priority changes while the mask is being edited.

// File: rtl/imask_intc.sv
module imask_intc #(
  parameter int NSRC     = 64,
  parameter int LVLW     = 3,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int VEC_BASE = 64,
  parameter int LVL_BASE = 64,
  parameter int MRD_BASE = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NSRC-1:0] irq_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [LVLW-1:0] irq_lvl_o,
  output logic [DW-1:0]   irq_vec_o
);
  localparam int IDXW    = $clog2(NSRC);
  localparam int ALL_BIT = IDXW;
  localparam int MBYTES  = (NSRC + 7) / 8;
  localparam logic [AW-1:0] SET_ADDR = AW'(0);
  localparam logic [AW-1:0] CLR_ADDR = AW'(1);

  logic [NSRC-1:0] mask_q;
  logic [LVLW-1:0] lvl_q [NSRC];
  logic [IDXW-1:0] cmd_idx;
  logic            idx_ok;
  logic            cmd_all;
  logic            set_wr, clr_wr;
  logic [LVLW-1:0] best_lvl;
  logic [IDXW-1:0] best_idx;

  assign cmd_idx = wr_data_i[IDXW-1:0];
  assign cmd_all = wr_data_i[ALL_BIT];
  assign set_wr  = wr_en_i && (wr_addr_i == SET_ADDR);
  assign clr_wr  = wr_en_i && (wr_addr_i == CLR_ADDR);

  generate
    if ((1 << IDXW) == NSRC) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_part
      assign idx_ok = (32'(cmd_idx) < NSRC);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q <= '1;
    end else if (set_wr) begin
      if (cmd_all)     mask_q <= '1;
      else if (idx_ok) mask_q[cmd_idx] <= 1'b1;
    end else if (clr_wr) begin
      if (cmd_all)     mask_q <= '0;
      else if (idx_ok) mask_q[cmd_idx] <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_lvl
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == AW'(LVL_BASE + g));
      always_ff @(posedge clk_i) begin
        if (rst_i)    lvl_q[g] <= '0;
        else if (hit) lvl_q[g] <= wr_data_i[LVLW-1:0];
      end
    end
  endgenerate

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_i[i] && !mask_q[i] && (lvl_q[i] > best_lvl)) begin
        best_lvl = lvl_q[i];
        best_idx = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_lvl_o <= '0;
      irq_vec_o <= '0;
    end else begin
      irq_lvl_o <= best_lvl;
      irq_vec_o <= (best_lvl != '0) ? DW'(VEC_BASE) + DW'(best_idx) : '0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < MBYTES; k++) begin
      if (rd_addr_i == AW'(MRD_BASE + k)) begin
        for (int b = 0; b < 8; b++) begin
          if (8 * k + b < NSRC) rd_data_o[b] = mask_q[8 * k + b];
        end
      end
    end
    for (int i = 0; i < NSRC; i++) begin
      if (rd_addr_i == AW'(LVL_BASE + i)) rd_data_o = DW'(lvl_q[i]);
    end
  end

  AST_SET_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_wr && !cmd_all && idx_ok) |=> mask_q[$past(cmd_idx)]); // R2
  AST_CLR_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_wr && !cmd_all && idx_ok) |=> !mask_q[$past(cmd_idx)]); // R3
  AST_SET_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_wr && cmd_all) |=> (&mask_q)); // R4
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_wr && cmd_all) |=> (mask_q == '0)); // R4
  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (rst_i)
    ((irq_i & ~mask_q) == '0) |=> (irq_lvl_o == '0 && irq_vec_o == '0)); // R7
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_lvl_o != '0) |-> (32'(irq_vec_o) >= VEC_BASE && 32'(irq_vec_o) < VEC_BASE + NSRC)); // R9
endmodule

// File: tb/imask_intc_tb.sv
`timescale 1ns/1ps
module imask_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0]  rd_data, vec;
  logic [2:0]  lvl;

  int tests = 0, fails = 0;
  bit done = 0;

  bit [63:0] m_mask;
  int        m_lvl [64];
  int        exp_lvl = 0, exp_vec = 0;

  always #2 clk = ~clk;

  imask_intc dut_i (
    .clk_i(clk), .rst_i(rst), .irq_i(irq), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_lvl_o(lvl), .irq_vec_o(vec)
  );

  function automatic int m_read(input int a);
    if (a >= 8 && a < 16) return int'(m_mask[(a - 8) * 8 +: 8]);
    if (a >= 64 && a < 128) return m_lvl[a - 64];
    return 0;
  endfunction

  task automatic m_write(input int a, input int d);
    if (a == 0) begin
      if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
    end else if (a == 1) begin
      if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
    end else if (a >= 64 && a < 128) begin
      m_lvl[a - 64] = d % 8;
    end
  endtask

  task automatic m_predict(input logic [63:0] src);
    int bl = 0, bi = 0;
    for (int i = 0; i < 64; i++)
      if (src[i] && !m_mask[i] && m_lvl[i] > bl) begin bl = m_lvl[i]; bi = i; end
    exp_lvl = bl;
    exp_vec = (bl != 0) ? 64 + bi : 0;
  endtask

  task automatic check(input string tag, input int act, input int expv, input string what);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic [63:0] src, input bit we,
                      input int a, input int d, input int ra);
    @(negedge clk);
    check(tag, int'(lvl), exp_lvl, "level");
    check(tag, int'(vec), exp_vec, "vector");
    check(tag, int'(rd_data), m_read(int'(rd_addr)), "readback");
    irq = src; wr_en = we; wr_addr = 8'(a); wr_data = 8'(d); rd_addr = 8'(ra);
    m_predict(src);
    if (we) m_write(a, d);
  endtask

  task automatic idle(input string tag, input logic [63:0] src, input int ra);
    step(tag, src, 1'b0, 0, 0, ra);
  endtask

  initial begin
    m_mask = '1;
    for (int i = 0; i < 64; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen through outputs and readback
    for (int k = 0; k < 8; k++) idle("R1", '0, 8 + k);
    idle("R1", '0, 64 + 20);
    // R5: level writes, upper data bits dropped
    step("R5", '0, 1, 64 + 5,  5,    64 + 5);
    step("R5", '0, 1, 64 + 9,  5,    64 + 9);
    step("R5", '0, 1, 64 + 20, 7,    64 + 20);
    step("R5", '0, 1, 64 + 30, 8'hFD, 64 + 30);
    idle("R5", '0, 64 + 30);
    // R2: all lines active but all masked
    idle("R2", '1, 8);
    idle("R2", '1, 8);
    // R3 + R9: unmask 9 alone
    step("R3", '1, 1, 1, 9, 9);
    idle("R9", '1, 9);
    idle("R9", '1, 8);
    // R8: unmask 5 ties with 9 at level 5
    step("R8", '1, 1, 1, 5, 8);
    idle("R8", '1, 8);
    idle("R8", '1, 8);
    // R7: unmask 20 at level 7
    step("R7", '1, 1, 1, 20, 10);
    idle("R7", '1, 10);
    idle("R7", 64'h0000_0000_0000_0200, 10);
    idle("R7", '0, 10);
    // R6: source 3 level 0 unmasked, only it active
    step("R6", 64'h8, 1, 1, 3, 8);
    idle("R6", 64'h8, 8);
    idle("R6", 64'h8, 8);
    // R2: re-mask 20
    step("R2", '1, 1, 0, 20, 10);
    idle("R2", '1, 10);
    idle("R2", '1, 10);
    // R11: unmapped writes have no effect
    step("R11", '1, 1, 2, 8'h05, 2);
    step("R11", '1, 1, 8, 8'h00, 8);
    step("R11", '1, 1, 200, 8'h07, 200);
    idle("R11", '1, 8);
    idle("R11", '1, 64 + 5);
    // R4: clear all with bit 6, then set all with 0xFF
    step("R4", '1, 1, 1, 8'h40, 12);
    idle("R4", '1, 12);
    idle("R4", '1, 15);
    step("R4", '1, 1, 0, 8'hFF, 12);
    idle("R4", '1, 12);
    idle("R4", '1, 15);
    step("R4", '1, 1, 1, 8'hC7, 8);
    idle("R4", '1, 8);
    // R10: random traffic compared cycle by cycle
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 9);
      int a, d;
      logic [63:0] s = {$urandom(), $urandom()};
      if (sel < 3)      a = 1;
      else if (sel < 5) a = 0;
      else if (sel < 8) a = 64 + $urandom_range(0, 63);
      else              a = $urandom_range(0, 255);
      d = (sel < 5) ? ((($urandom_range(0, 15) == 0) ? 8'h40 : 8'h00) | $urandom_range(0, 63))
                    : $urandom_range(0, 255);
      step("R10", s, $urandom_range(0, 3) != 0, a, d, $urandom_range(0, 130));
    end
    idle("R10", '0, 0);
    idle("R10", '0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule